// File: doc/BRIEF.md
# Secure Power-Control Register Bank with Single-Bit Set/Clear Aliases

This block holds the 32-bit control words of a power-management controller. Several bus masters share these words. A master can change one bit without reading the word first, so no other master's update is lost. The top two bits of the 16-bit byte address choose the access window: the plain window, a set window or a clear window. In the set and clear windows, the write data is not a value. It is the number of the single bit to force high or low.

Only secure masters may write, and this applies to every window. Reads are open to every master. In the set and clear windows a read returns the plain contents of the word. A few words are marked as plain-only and accept full-word writes alone. A refused access leaves every word unchanged and raises a one-cycle error response. Each access is a single-cycle strobe. Read data and the error flag are registered, so they appear in the cycle after the strobe.

Top module: `pmu_secure_regbank`

## Requirements
- R1: After reset every word reads as zero and `err_o` is low.
- R2: A secure write with address bits [15:14] = 00 stores all 32 data bits into word `addr_i[13:2]` at the next clock edge. A read returns the word on `rdata_o` in the cycle after `rd_i`.
- R3: A secure write with address bits [15:14] = 11 sets bit `wdata_i[4:0]` of the addressed word. No other bit of any word changes.
- R4: A secure write with address bits [15:14] = 10 clears bit `wdata_i[4:0]` of the addressed word. No other bit of any word changes.
- R5: A write with `secure_i` low changes no word and raises `err_o` in the next cycle. A read with `secure_i` low completes normally.
- R6: A set or clear write whose data value is above 31 changes no word and raises `err_o`.
- R7: Words whose bit is set in `NOALIAS_MASK` (by default words 0 and 1) refuse set and clear writes with `err_o`. These words still accept plain writes.
- R8: A read in the set or clear window returns the addressed word's current contents without error.
- R9: The following accesses change no word and raise `err_o`: a word index at or above `NUM_REGS`, a non-zero `addr_i[1:0]`, or the reserved window [15:14] = 01. Such reads return zero.
- R10: `err_o` is high only in the cycle after a strobe. When `wr_i` and `rd_i` are both high, only the write is performed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 16 | Byte address: [15:14] window, [13:2] word index, [1:0] must be zero |
| wdata_i | input | 32 | Write value in the plain window, bit number in the set and clear windows |
| wr_i | input | 1 | Write strobe, one cycle |
| rd_i | input | 1 | Read strobe, one cycle |
| secure_i | input | 1 | High when the requesting master is secure |
| rdata_o | output | 32 | Read data, valid the cycle after `rd_i` |
| err_o | output | 1 | Error response, the cycle after a refused access |

## Verification
On every cycle, the assertions check four things:
- An alias write changes at most one bit across the whole bank.
- Refused writes (non-secure, bad bit number, plain-only word) leave the bank untouched and raise the error.
- The bank holds its contents when no write is enabled.
- The error flag stays low after idle cycles.

The bench scenarios show the rest:
- The exact bit that moves, and its polarity.
- Full-word storage.
- That alias-window reads return the plain word.
- The zero data on refused reads.
- The out-of-range, misaligned and reserved-window cases against an independent model of the bank.

// File: rtl/pmu_regbank_pkg.sv
package pmu_regbank_pkg;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 32;
  localparam int OFS_W  = 12;  // word index field addr[13:2]

  typedef enum logic [1:0] {
    WIN_PLAIN = 2'b00,
    WIN_RSVD  = 2'b01,
    WIN_CLR   = 2'b10,
    WIN_SET   = 2'b11
  } win_e;
endpackage

// File: rtl/pmu_alias_decode.sv
module pmu_alias_decode
  import pmu_regbank_pkg::*;
#(
  parameter int NUM_REGS = 16,
  localparam int IDX_W = $clog2(NUM_REGS)
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output win_e              win_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic              target_ok_o,
  output logic              bit_ok_o,
  output logic [4:0]        bit_sel_o
);
  logic [OFS_W-1:0] ofs;

  assign ofs         = addr_i[13:2];
  assign win_o       = win_e'(addr_i[15:14]);
  assign idx_o       = ofs[IDX_W-1:0];
  assign target_ok_o = (ofs < OFS_W'(NUM_REGS)) && (addr_i[1:0] == 2'b00)
                       && (win_o != WIN_RSVD);
  assign bit_ok_o    = (wdata_i[DATA_W-1:5] == '0);
  assign bit_sel_o   = wdata_i[4:0];
endmodule

// File: rtl/pmu_access_policy.sv
module pmu_access_policy
  import pmu_regbank_pkg::*;
#(
  parameter int NUM_REGS = 16,
  parameter logic [NUM_REGS-1:0] NOALIAS_MASK = NUM_REGS'(3),
  localparam int IDX_W = $clog2(NUM_REGS)
) (
  input  logic             wr_i,
  input  logic             rd_i,
  input  logic             secure_i,
  input  win_e             win_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic             target_ok_i,
  input  logic             bit_ok_i,
  output logic             we_o,
  output logic             rd_en_o,
  output logic             err_o
);
  logic is_alias, alias_bad, wr_bad;

  assign is_alias  = (win_i == WIN_SET) || (win_i == WIN_CLR);
  assign alias_bad = is_alias && target_ok_i && (NOALIAS_MASK[idx_i] || !bit_ok_i);
  assign wr_bad    = !secure_i || !target_ok_i || alias_bad;

  always_comb begin
    we_o    = 1'b0;
    rd_en_o = 1'b0;
    err_o   = 1'b0;
    if (wr_i) begin              // write wins over a simultaneous read
      we_o  = !wr_bad;
      err_o = wr_bad;
    end else if (rd_i) begin
      rd_en_o = target_ok_i;
      err_o   = !target_ok_i;
    end
  end
endmodule

// File: rtl/pmu_reg_array.sv
module pmu_reg_array
  import pmu_regbank_pkg::*;
#(
  parameter int NUM_REGS = 16,
  localparam int IDX_W = $clog2(NUM_REGS)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       we_i,
  input  win_e                       win_i,
  input  logic [IDX_W-1:0]           idx_i,
  input  logic [4:0]                 bit_sel_i,
  input  logic [DATA_W-1:0]          wdata_i,
  output logic [DATA_W-1:0]          rd_word_o,
  output logic [NUM_REGS*DATA_W-1:0] q_flat_o
);
  logic [DATA_W-1:0] q [NUM_REGS];
  logic [DATA_W-1:0] bit_mask;

  assign bit_mask = DATA_W'(1) << bit_sel_i;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_word
    logic hit;
    assign hit = we_i && (idx_i == IDX_W'(g));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        q[g] <= '0;
      end else if (hit) begin
        unique case (win_i)
          WIN_SET: q[g] <= q[g] | bit_mask;
          WIN_CLR: q[g] <= q[g] & ~bit_mask;
          default: q[g] <= wdata_i;
        endcase
      end
    end
    assign q_flat_o[g*DATA_W +: DATA_W] = q[g];
  end

  assign rd_word_o = q[idx_i];

  a_r2_hold_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(q_flat_o));
endmodule

// File: rtl/pmu_secure_regbank.sv
module pmu_secure_regbank
  import pmu_regbank_pkg::*;
#(
  parameter int NUM_REGS = 16,
  parameter logic [NUM_REGS-1:0] NOALIAS_MASK = NUM_REGS'(3),
  localparam int IDX_W = $clog2(NUM_REGS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [15:0]       addr_i,
  input  logic [31:0]       wdata_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic              secure_i,
  output logic [31:0]       rdata_o,
  output logic              err_o
);
  win_e                       win;
  logic [IDX_W-1:0]           idx;
  logic [4:0]                 bit_sel;
  logic                       target_ok, bit_ok, we, rd_en, err_d;
  logic [DATA_W-1:0]          rd_word;
  logic [NUM_REGS*DATA_W-1:0] q_flat;

  pmu_alias_decode #(.NUM_REGS(NUM_REGS)) u_dec (
    .addr_i(addr_i), .wdata_i(wdata_i), .win_o(win), .idx_o(idx),
    .target_ok_o(target_ok), .bit_ok_o(bit_ok), .bit_sel_o(bit_sel)
  );

  pmu_access_policy #(.NUM_REGS(NUM_REGS), .NOALIAS_MASK(NOALIAS_MASK)) u_pol (
    .wr_i(wr_i), .rd_i(rd_i), .secure_i(secure_i), .win_i(win), .idx_i(idx),
    .target_ok_i(target_ok), .bit_ok_i(bit_ok),
    .we_o(we), .rd_en_o(rd_en), .err_o(err_d)
  );

  pmu_reg_array #(.NUM_REGS(NUM_REGS)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(we), .win_i(win), .idx_i(idx),
    .bit_sel_i(bit_sel), .wdata_i(wdata_i), .rd_word_o(rd_word), .q_flat_o(q_flat)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o <= '0;
      err_o   <= 1'b0;
    end else begin
      err_o <= err_d;
      if (rd_i && !wr_i) rdata_o <= rd_en ? rd_word : '0;
    end
  end

  a_r5_nonsecure_refused: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && !secure_i |=> err_o && $stable(q_flat));
  // R3 and R4
  a_r3_alias_one_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && addr_i[15] |=> $countones(q_flat ^ $past(q_flat)) <= 1);
  a_r6_bad_index: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && addr_i[15] && (wdata_i[31:5] != '0) |=> err_o && $stable(q_flat));
  a_r7_noalias_refused: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && addr_i[15] && (addr_i[13:2] < 12'(NUM_REGS)) && NOALIAS_MASK[idx]
    |=> err_o && $stable(q_flat));
  a_r10_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i && !rd_i |=> !err_o);
endmodule

// File: tb/pmu_secure_regbank_test.sv
`timescale 1ns/1ps
module pmu_secure_regbank_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] addr = '0;
  logic [31:0] wdata = '0;
  logic        wr = 1'b0, rd = 1'b0, sec = 1'b0;
  logic [31:0] rdata;
  logic        err;

  typedef struct {
    bit          chk_d;
    logic [31:0] d;
    bit          e;
    string       tag;
  } exp_t;

  exp_t        exp_q[$];
  logic [31:0] model [16];
  int          n_cmp = 0, n_bad = 0;

  always #10 clk = ~clk;

  pmu_secure_regbank uut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata),
    .wr_i(wr), .rd_i(rd), .secure_i(sec), .rdata_o(rdata), .err_o(err)
  );

  // words 0 and 1 are plain-only (R7)
  task automatic op(bit w, bit r, bit s, logic [15:0] a, logic [31:0] d, string tag);
    exp_t        x;
    int          ofs;
    bit          ok, alias_w;
    @(negedge clk);
    wr = w; rd = r; sec = s; addr = a; wdata = d;
    ofs     = int'(a[13:2]);
    ok      = (ofs < 16) && (a[1:0] == 2'b00) && (a[15:14] != 2'b01);
    alias_w = a[15];
    x.tag   = tag;
    x.chk_d = 1'b0;
    x.d     = '0;
    if (w) begin
      x.e = !s || !ok || (alias_w && (ofs < 2 || d > 31));
      if (!x.e) begin
        if (a[15:14] == 2'b11)      model[ofs] = model[ofs] | (32'd1 << d[4:0]);
        else if (a[15:14] == 2'b10) model[ofs] = model[ofs] & ~(32'd1 << d[4:0]);
        else                        model[ofs] = d;
      end
    end else begin
      x.e     = !ok;
      x.chk_d = 1'b1;
      x.d     = ok ? model[ofs] : 32'd0;
    end
    exp_q.push_back(x);
    @(negedge clk);
    wr = 1'b0; rd = 1'b0;
  endtask

  // monitor: compare in the cycle after each strobe, idle cycles expect no error
  always begin
    bit   had;
    exp_t x;
    @(posedge clk);
    had = wr || rd;
    #5;
    if (rst_n) begin
      if (had && exp_q.size() > 0) begin
        x = exp_q.pop_front();
        n_cmp++;
        if (err !== x.e) begin
          n_bad++;
          $display("FAIL %s err: got %0b exp %0b", x.tag, err, x.e);
        end
        if (x.chk_d) begin
          n_cmp++;
          if (rdata !== x.d) begin
            n_bad++;
            $display("FAIL %s rdata: got %08h exp %08h", x.tag, rdata, x.d);
          end
        end
      end else if (!had) begin
        n_cmp++;
        if (err !== 1'b0) begin
          n_bad++;
          $display("FAIL R10 idle err: got %0b exp 0", err);
        end
      end
    end
  end

  initial begin
    #(20 * 200000);
    n_bad++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    for (int i = 0; i < 16; i++) op(0, 1, 1, 16'(i * 4), 0, "R1");
    // R2 plain writes and read back
    op(1, 0, 1, 16'h0014, 32'hA5A5_0F0F, "R2");
    op(0, 1, 1, 16'h0014, 0, "R2");
    op(1, 0, 1, 16'h003C, 32'hFFFF_0001, "R2");
    op(0, 1, 1, 16'h003C, 0, "R2");
    // R3 set alias, including bit 31 and an already-set bit
    op(1, 0, 1, 16'hC014, 32'd4, "R3");
    op(0, 1, 1, 16'h0014, 0, "R3");
    op(1, 0, 1, 16'hC008, 32'd31, "R3");
    op(0, 1, 1, 16'h0008, 0, "R3");
    op(1, 0, 1, 16'hC014, 32'd0, "R3");
    op(0, 1, 1, 16'h0014, 0, "R3");
    // R4 clear alias
    op(1, 0, 1, 16'h8014, 32'd0, "R4");
    op(0, 1, 1, 16'h0014, 0, "R4");
    op(1, 0, 1, 16'h803C, 32'd31, "R4");
    op(0, 1, 1, 16'h003C, 0, "R4");
    // R5 non-secure write refused, non-secure read allowed
    op(1, 0, 0, 16'h0014, 32'h1234_5678, "R5");
    op(1, 0, 0, 16'hC014, 32'd1, "R5");
    op(0, 1, 0, 16'h0014, 0, "R5");
    // R6 bit number out of range
    op(1, 0, 1, 16'hC014, 32'd32, "R6");
    op(1, 0, 1, 16'h8014, 32'h8000_0000, "R6");
    op(0, 1, 1, 16'h0014, 0, "R6");
    // R7 plain-only words
    op(1, 0, 1, 16'hC000, 32'd3, "R7");
    op(0, 1, 1, 16'h0000, 0, "R7");
    op(1, 0, 1, 16'h0004, 32'hDEAD_BEEF, "R7");
    op(1, 0, 1, 16'h8004, 32'd0, "R7");
    op(0, 1, 1, 16'h0004, 0, "R7");
    // R8 reads through alias windows
    op(0, 1, 1, 16'hC014, 0, "R8");
    op(0, 1, 0, 16'h8004, 0, "R8");
    // R9 out of range, misaligned, reserved window
    op(0, 1, 1, 16'h0040, 0, "R9");
    op(1, 0, 1, 16'h0040, 32'h1, "R9");
    op(1, 0, 1, 16'h0015, 32'h1, "R9");
    op(0, 1, 1, 16'h0016, 0, "R9");
    op(1, 0, 1, 16'h4014, 32'h0, "R9");
    op(0, 1, 1, 16'h4014, 0, "R9");
    op(0, 1, 1, 16'h0014, 0, "R9");
    // R10 write wins over simultaneous read, then idle cycles
    op(1, 1, 1, 16'h0020, 32'h0000_00AA, "R10");
    op(0, 1, 1, 16'h0020, 0, "R10");
    repeat (4) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule